// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on a two-wire serial management bus: a clock it drives (MDC) and one shared data line (MDIO). A requester presents a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then clocks out one complete frame, most significant bit first. MDC is produced from the system clock by a counter, and each MDC level lasts `HALF` system cycles.

On a write, the block drives the whole frame, including the turnaround and the data word. After the last bit it releases the line. On a read, it stops driving after the register address and shifts in 17 bits. These are the turnaround slot followed by 16 data bits. It keeps the last 16 bits as the read result. A single-cycle `done` pulse marks the end of every frame and presents the read data. `busy` stays high for the whole frame, and the block ignores any request that arrives while `busy` is high.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 driven one bits on MDIO, followed by the start pattern 0 then 1.
- R2: The two-bit operation code follows the start pattern: 1,0 for a read and 0,1 for a write. After it come the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R3: A write frame then drives the turnaround as 1,0 and the 16 data bits MSB first, for 64 driven bits in total.
- R4: A read frame drives exactly 46 bits and deasserts `mdio_oe` for all later slots. It samples MDIO at each of the next 17 MDC rising edges. The first sample (turnaround) is discarded, and `rdata` holds the other 16 samples, first sample in bit 15.
- R5: Each MDC high level lasts exactly `HALF` system cycles. A frame takes 2·`HALF`·N cycles from acceptance to `done`, where N is 64 for a write and 63 for a read.
- R6: `mdio_out` changes only while MDC is low. It never changes between two consecutive cycles in which MDC is high.
- R7: `busy` goes high in the cycle after a request is accepted with `req_valid` while idle. It stays high until the frame ends. Requests presented while `busy` is high have no effect on the frame in progress, and no frame follows them.
- R8: `done` is high for exactly one cycle at the end of each frame. In that cycle `busy` is low, MDC is low and `mdio_oe` is low. While idle, MDC and `mdio_oe` stay low.
- R9: A synchronous active-high `rst` returns the block to idle in the next cycle, with MDC low, `mdio_oe` low and `busy` and `done` low. This also applies in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_read | input | 1 | 1 selects a read frame, 0 a write frame |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Data returned by the last read frame |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive when enabled |
| mdio_oe | output | 1 | MDIO tristate output enable |
| mdio_in | input | 1 | Sampled MDIO line |

## Verification
The bound checker watches every cycle for these properties: the MDC high width, `mdio_out` holding still while MDC is high, the line being released during the read-back slots and while idle, the preamble level, the single-cycle `done`, and the latched opcode not changing during a frame. Several things can only be shown by the bench's scenarios, using a bus model that captures driven bits on MDC rising edges and answers reads: the exact bit order of every field, the total frame length, the discarding of the turnaround sample, the ignoring of requests made while busy, and reset in the middle of a frame. The bench sweeps all 32 PHY and register addresses for both reads and writes.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  localparam int CW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int RX_FIRST = 46;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t      st;
  logic [CW-1:0] cnt;
  logic [63:0] sh;
  logic [5:0]  idx;
  logic        rd;
  logic [16:0] rx;

  wire tick = (cnt == TOP);
  wire [5:0] last = rd ? 6'd62 : 6'd63;

  assign busy     = (st != S_IDLE);
  assign mdio_out = mdio_oe & sh[63];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      idx     <= '0;
      rd      <= 1'b0;
      rx      <= '0;
      mdc     <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st      <= S_LOW;
            cnt     <= '0;
            idx     <= '0;
            rd      <= req_read;
            rx      <= '0;
            mdio_oe <= 1'b1;
            sh      <= {32'hFFFF_FFFF, 2'b01, (req_read ? 2'b10 : 2'b01),
                        req_phy, req_reg, 2'b10, req_wdata};
          end
        end
        S_LOW: begin
          if (tick) begin
            st  <= S_HIGH;
            mdc <= 1'b1;
            cnt <= '0;
            if (rd && idx >= 6'(RX_FIRST)) rx <= {rx[15:0], mdio_in};
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (tick) begin
            cnt <= '0;
            mdc <= 1'b0;
            if (idx == last) begin
              st      <= S_IDLE;
              mdio_oe <= 1'b0;
              done    <= 1'b1;
              if (rd) rdata <= rx[15:0];
            end else begin
              st  <= S_LOW;
              idx <= idx + 1'b1;
              sh  <= {sh[62:0], 1'b0};
              if (rd && idx == 6'(RX_FIRST - 1)) mdio_oe <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module mdio_master_chk #(
  parameter int HALF = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       mdc,
  input logic       mdio_out,
  input logic       mdio_oe,
  input logic       rd,
  input logic [5:0] idx
);

  logic        prev_mdc;
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mdc <= 1'b0;
      run      <= '0;
    end else begin
      prev_mdc <= mdc;
      run      <= (mdc != prev_mdc) ? 32'd1 : run + 32'd1;
    end
  end

  p_mdc_high_width_r5: assert property (@(posedge clk) disable iff (rst)
    (prev_mdc && !mdc) |-> run == 32'(HALF));

  p_out_steady_high_r6: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_out));

  p_preamble_ones_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && idx < 6'd32) |-> (mdio_oe && mdio_out));

  p_read_release_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && rd && idx >= 6'd46) |-> !mdio_oe);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_op_held_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd));

endmodule

bind mdio_master mdio_master_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd(rd), .idx(idx)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdio_out, mdio_oe;
  logic [15:0] rdata;
  logic mdio_in = 1'b0;

  always #2 clk = ~clk;

  mdio_master #(.HALF(HALF)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int vecs = 0, errs = 0;
  int rise_n = 0, drv_n = 0;
  logic [63:0] cap = '0;
  logic cur_rd = 1'b0, ta_bit = 1'b0;
  logic [15:0] phy_data = '0;
  logic prev_mdc = 1'b0, prev_out = 1'b0, r6_bad = 1'b0;
  int cycles = 0;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_out};
      drv_n++;
    end
    rise_n++;
  end

  always @(negedge mdc) begin
    if (cur_rd && rise_n >= 46 && rise_n <= 62)
      mdio_in = (rise_n == 46) ? ta_bit : phy_data[15 - (rise_n - 47)];
    else
      mdio_in = 1'b0;
  end

  always @(negedge clk) begin
    if (mdc && prev_mdc && mdio_out != prev_out) r6_bad = 1'b1;
    prev_mdc = mdc;
    prev_out = mdio_out;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rdf, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd,
                           input logic [15:0] resp, input logic ta);
    int cyc;
    int nbits;
    logic [63:0] exp;
    @(negedge clk);
    cap = '0; drv_n = 0; rise_n = 0; r6_bad = 1'b0;
    cur_rd = rdf; phy_data = resp; ta_bit = ta;
    req_valid = 1'b1; req_read = rdf; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin
        req_valid = 1'b1; req_read = ~rdf; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      end
      if (cyc == 8) req_valid = 1'b0;
    end
    nbits = rdf ? 63 : 64;
    chk(cyc == 2*HALF*nbits + 1, "R5 frame length", 64'(cyc), 64'(2*HALF*nbits + 1));
    chk(!busy && !mdc && !mdio_oe, "R8 idle at done", {61'd0, busy, mdc, mdio_oe}, 64'd0);
    chk(r6_bad == 1'b0, "R6 data moved while MDC high", 64'(r6_bad), 64'd0);
    if (rdf) begin
      exp = {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
      chk(drv_n == 46, "R4 driven bit count", 64'(drv_n), 64'd46);
      chk(cap[45:12] == exp[45:12], "R1 preamble and start", cap, exp);
      chk(cap[11:0] == exp[11:0], "R2 read opcode and addresses", cap, exp);
      chk(rdata == resp, "R4 read data", 64'(rdata), 64'(resp));
    end else begin
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wd};
      chk(drv_n == 64, "R3 driven bit count", 64'(drv_n), 64'd64);
      chk(cap[63:30] == exp[63:30], "R1 preamble and start", cap, exp);
      chk(cap[29:18] == exp[29:18], "R2 write opcode and addresses", cap, exp);
      chk(cap[17:0] == exp[17:0], "R3 turnaround and data", cap, exp);
    end
    @(negedge clk);
    chk(!done && !busy, "R7 no frame after ignored request", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R9 reset state",
        {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      d = 16'(i * 16'h0841) ^ 16'hA5C3;
      run_frame(1'b0, 5'(i), 5'(31 - i), d, 16'h0, 1'b0);
      run_frame(1'b1, 5'(31 - i), 5'(i), 16'h0, ~d ^ 16'(i << 3), i[0]);
    end
    run_frame(1'b1, 5'd3, 5'd17, 16'h0, 16'hFFFF, 1'b1);
    run_frame(1'b1, 5'd3, 5'd17, 16'h0, 16'h0000, 1'b1);
    run_frame(1'b0, 5'd31, 5'd0, 16'h8001, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_phy = 5'd9; req_reg = 5'd4; req_wdata = 16'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !mdc && !mdio_oe, "R9 reset mid-frame",
        {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
    repeat (20) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R8 stays idle after reset",
        {61'd0, busy, mdc, mdio_oe}, 64'd0);
    run_frame(1'b1, 5'd1, 5'd2, 16'h0, 16'h5A3C, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule